// File: doc/BRIEF.md
# Directory Home-Node Write Serializer

This block is the home-node directory controller for a fixed set of cache lines shared by a group of nodes. For each line it stores a stable state (Uncached, Shared or Exclusive), a sharer bit per node, and an owner or pending-requester ID. Read and write requests arrive on one valid/ready port. Invalidations leave on a second port. Acknowledgements from invalidated nodes come back on a third. Data replies, ownership grants and refusals leave on a fourth. Every message carries a node ID and a line index.

A write to a line that other nodes hold cannot complete on the spot. The line enters a transient busy state and the block sends one invalidation to each other holder. A per-line counter then counts the acknowledgements as they return. The grant of data and ownership is released only when the final acknowledgement arrives, and that grant is the write's commit point. While the line is busy, every competing request to it is refused with a NACK so that the requester retries. As a result, each write appears atomic to all nodes.

The block accepts at most one incoming message per clock. Acknowledgements take priority over requests, because an acknowledgement must always drain. Input is held back while the reply register is full and stalled. Invalidations are queued per line and issued one per cycle from a separate output register.

Top module: `dir_home_serializer`

## Requirements
- R1: After reset every line is Uncached and no reply or invalidation is valid. A first read of any line is answered with a data reply and triggers no invalidation.
- R2: A read to a Shared or Uncached line that is not busy is answered with a data reply (kind 0) to the requester. The requester is added to the sharers and the line ends Shared.
- R3: A write to an Uncached line, to a line whose only holder is the requester, or to a line the requester already owns is answered at once with a grant (kind 1). No invalidation is sent and the line ends Exclusive with the requester as owner.
- R4: A write to a line that other nodes hold sends exactly one invalidation to each holder other than the requester. Invalidations go out in ascending node order, one per cycle, and none goes to the requester.
- R5: The grant for such a write goes out only after the line has received as many acknowledgements as invalidations were sent. It follows the last acknowledgement by one cycle, and no reply is sent before that.
- R6: Any read or write to a busy line is answered with a NACK (kind 2) and leaves the line's state, holders and pending writer unchanged.
- R7: A read by another node to an Exclusive line invalidates the owner. After the acknowledgement the reader gets a data reply and becomes the line's only sharer.
- R8: At most one message is accepted per cycle. When an acknowledgement and a request are both valid, the acknowledgement is taken and the request waits with its ready low.
- R9: While a reply is valid and not accepted, its fields stay stable and neither input port is ready.
- R10: While an invalidation is valid and not accepted, its fields stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle |
| req_write | input | 1 | 1 = write (ownership) request, 0 = read |
| req_node | input | NID_W | Requesting node |
| req_line | input | LID_W | Line index |
| ack_valid | input | 1 | Invalidation acknowledgement present |
| ack_ready | output | 1 | Acknowledgement accepted |
| ack_node | input | NID_W | Acknowledging node |
| ack_line | input | LID_W | Line acknowledged |
| inv_valid | output | 1 | Invalidation present |
| inv_ready | input | 1 | Invalidation taken by the network |
| inv_node | output | NID_W | Node to invalidate |
| inv_line | output | LID_W | Line to invalidate |
| rsp_valid | output | 1 | Reply present |
| rsp_ready | input | 1 | Reply taken by the network |
| rsp_kind | output | 2 | 0 data, 1 grant, 2 NACK |
| rsp_node | output | NID_W | Destination node |
| rsp_line | output | LID_W | Line index |

## Verification
Replies to requests become valid one cycle after the request handshake. The grant of a serialized write becomes valid one cycle after the last acknowledgement handshake. The first invalidation of a write becomes valid two cycles after the write's handshake, and the rest follow one per cycle. The bench does not wait a fixed delay for any of these. It pushes each expected reply or invalidation into a queue before driving the stimulus, and a monitor pops and compares every transfer in the cycle it happens. A reply that shows up early, such as a grant before the last acknowledgement, finds the queue empty and is reported. Stall behaviour is checked by sampling the held outputs cycle by cycle while the bench holds the ready inputs low.

// File: rtl/dhs_pkg.sv
package dhs_pkg;
   typedef enum logic [1:0] {
      LS_UNC  = 2'd0,
      LS_SHR  = 2'd1,
      LS_EXC  = 2'd2,
      LS_BUSY = 2'd3
   } line_st_t;

   typedef enum logic [1:0] {
      RK_DATA  = 2'd0,
      RK_GRANT = 2'd1,
      RK_NACK  = 2'd2
   } rsp_kind_t;

   typedef enum logic [2:0] {
      ACT_NONE,
      ACT_ADD_SHR,
      ACT_GRANT,
      ACT_BUSY,
      ACT_ACK_DEC,
      ACT_ACK_DONE
   } dir_act_t;
endpackage

// File: rtl/dhs_msg_reg.sv
module dhs_msg_reg #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] din,
   output logic         valid_o,
   input  logic         ready_i,
   output logic [W-1:0] dout
);
   if (W < 1) begin : g_bad_w
      $error("dhs_msg_reg: W must be positive");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_o <= 1'b0;
         dout    <= '0;
      end else if (load) begin
         valid_o <= 1'b1;
         dout    <= din;
      end else if (ready_i) begin
         valid_o <= 1'b0;
      end
   end

   // R9 for the reply instance, R10 for the invalidation instance
   assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o && !ready_i |=> valid_o && $stable(dout));
endmodule

// File: rtl/dhs_inv_sched.sv
module dhs_inv_sched #(
   parameter int NODES = 4,
   parameter int LINES = 8,
   parameter int NID_W = 2,
   parameter int LID_W = 3
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [LINES*NODES-1:0] pend_flat,
   output logic                   inv_valid,
   input  logic                   inv_ready,
   output logic [NID_W-1:0]       inv_node,
   output logic [LID_W-1:0]       inv_line,
   output logic                   clr_en,
   output logic [NID_W-1:0]       clr_node,
   output logic [LID_W-1:0]       clr_line
);
   logic found;

   // lowest line first, then lowest node within the line (R4 ordering)
   always_comb begin
      found    = 1'b0;
      clr_node = '0;
      clr_line = '0;
      for (int l = 0; l < LINES; l++) begin
         for (int n = 0; n < NODES; n++) begin
            if (!found && pend_flat[l*NODES+n]) begin
               found    = 1'b1;
               clr_node = NID_W'(n);
               clr_line = LID_W'(l);
            end
         end
      end
      clr_en = found && (!inv_valid || inv_ready);
   end

   dhs_msg_reg #(.W(NID_W + LID_W)) u_inv_reg (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (clr_en),
      .din     ({clr_node, clr_line}),
      .valid_o (inv_valid),
      .ready_i (inv_ready),
      .dout    ({inv_node, inv_line})
   );
endmodule

// File: rtl/dir_home_serializer.sv
module dir_home_serializer
   import dhs_pkg::*;
#(
   parameter int NODES = 4,
   parameter int LINES = 8,
   parameter int NID_W = (NODES > 1) ? $clog2(NODES) : 1,
   parameter int LID_W = (LINES > 1) ? $clog2(LINES) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic             req_write,
   input  logic [NID_W-1:0] req_node,
   input  logic [LID_W-1:0] req_line,
   input  logic             ack_valid,
   output logic             ack_ready,
   input  logic [NID_W-1:0] ack_node,
   input  logic [LID_W-1:0] ack_line,
   output logic             inv_valid,
   input  logic             inv_ready,
   output logic [NID_W-1:0] inv_node,
   output logic [LID_W-1:0] inv_line,
   output logic             rsp_valid,
   input  logic             rsp_ready,
   output logic [1:0]       rsp_kind,
   output logic [NID_W-1:0] rsp_node,
   output logic [LID_W-1:0] rsp_line
);
   localparam int CNT_W = $clog2(NODES + 1);
   localparam int RSP_W = 2 + NID_W + LID_W;

   if (NODES < 2 || NODES > (1 << NID_W)) begin : g_bad_nodes
      $error("dir_home_serializer: NODES does not fit NID_W");
   end
   if (LINES < 1 || LINES > (1 << LID_W)) begin : g_bad_lines
      $error("dir_home_serializer: LINES does not fit LID_W");
   end

   function automatic logic [CNT_W-1:0] count_ones(input logic [NODES-1:0] v);
      logic [CNT_W-1:0] c;
      c = '0;
      for (int i = 0; i < NODES; i++) c = c + CNT_W'(v[i]);
      return c;
   endfunction

   // per-line directory storage
   line_st_t         st_q   [LINES];
   logic [NODES-1:0] shr_q  [LINES];
   logic [NID_W-1:0] own_q  [LINES];  // owner, or pending requester while busy
   logic [CNT_W-1:0] cnt_q  [LINES];
   logic             wr_q   [LINES];  // busy transaction is a write
   logic [NODES-1:0] pend_q [LINES];  // invalidations not yet issued

   logic                   slot_free, ack_fire, req_fire;
   logic [NODES-1:0]       self_bit, others;
   dir_act_t               act;
   logic [LID_W-1:0]       act_line;
   logic                   rsp_load;
   rsp_kind_t              nk;
   logic [NID_W-1:0]       nn;
   logic [LINES*NODES-1:0] pend_flat;
   logic                   clr_en;
   logic [NID_W-1:0]       clr_node;
   logic [LID_W-1:0]       clr_line;

   assign slot_free = !rsp_valid || rsp_ready;
   assign ack_ready = slot_free;
   assign req_ready = slot_free && !ack_valid;
   assign ack_fire  = ack_valid && ack_ready;
   assign req_fire  = req_valid && req_ready;
   assign self_bit  = NODES'(1) << req_node;
   assign others    = shr_q[req_line] & ~self_bit;

   always_comb begin
      act      = ACT_NONE;
      act_line = req_line;
      rsp_load = 1'b0;
      nk       = RK_DATA;
      nn       = req_node;
      if (ack_fire) begin
         act_line = ack_line;
         if (cnt_q[ack_line] == CNT_W'(1)) begin
            act      = ACT_ACK_DONE;
            rsp_load = 1'b1;
            nk       = wr_q[ack_line] ? RK_GRANT : RK_DATA;
            nn       = own_q[ack_line];
         end else begin
            act = ACT_ACK_DEC;
         end
      end else if (req_fire) begin
         if (st_q[req_line] == LS_BUSY) begin
            rsp_load = 1'b1;
            nk       = RK_NACK;
         end else if (others == '0) begin
            rsp_load = 1'b1;
            if (req_write) begin
               nk  = RK_GRANT;
               act = ACT_GRANT;
            end else if (st_q[req_line] != LS_EXC) begin
               act = ACT_ADD_SHR;
            end
         end else if (!req_write && st_q[req_line] == LS_SHR) begin
            rsp_load = 1'b1;
            act      = ACT_ADD_SHR;
         end else begin
            act = ACT_BUSY;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int l = 0; l < LINES; l++) begin
            st_q[l]   <= LS_UNC;
            shr_q[l]  <= '0;
            own_q[l]  <= '0;
            cnt_q[l]  <= '0;
            wr_q[l]   <= 1'b0;
            pend_q[l] <= '0;
         end
      end else begin
         if (clr_en) pend_q[clr_line][clr_node] <= 1'b0;
         case (act)
            ACT_ADD_SHR: begin
               st_q[act_line]  <= LS_SHR;
               shr_q[act_line] <= shr_q[act_line] | self_bit;
            end
            ACT_GRANT: begin
               st_q[act_line]  <= LS_EXC;
               shr_q[act_line] <= self_bit;
               own_q[act_line] <= req_node;
            end
            ACT_BUSY: begin
               st_q[act_line]   <= LS_BUSY;
               own_q[act_line]  <= req_node;
               wr_q[act_line]   <= req_write;
               cnt_q[act_line]  <= count_ones(others);
               pend_q[act_line] <= others;
            end
            ACT_ACK_DEC: cnt_q[act_line] <= cnt_q[act_line] - CNT_W'(1);
            ACT_ACK_DONE: begin
               cnt_q[act_line] <= '0;
               st_q[act_line]  <= wr_q[act_line] ? LS_EXC : LS_SHR;
               shr_q[act_line] <= NODES'(1) << own_q[act_line];
            end
            default: ;
         endcase
      end
   end

   always_comb begin
      for (int l = 0; l < LINES; l++)
         for (int n = 0; n < NODES; n++)
            pend_flat[l*NODES+n] = pend_q[l][n];
   end

   dhs_inv_sched #(
      .NODES(NODES), .LINES(LINES), .NID_W(NID_W), .LID_W(LID_W)
   ) u_sched (
      .clk       (clk),
      .rst_n     (rst_n),
      .pend_flat (pend_flat),
      .inv_valid (inv_valid),
      .inv_ready (inv_ready),
      .inv_node  (inv_node),
      .inv_line  (inv_line),
      .clr_en    (clr_en),
      .clr_node  (clr_node),
      .clr_line  (clr_line)
   );

   dhs_msg_reg #(.W(RSP_W)) u_rsp_reg (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (rsp_load),
      .din     ({nk, nn, act_line}),
      .valid_o (rsp_valid),
      .ready_i (rsp_ready),
      .dout    ({rsp_kind, rsp_node, rsp_line})
   );

   assert_nack_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
      req_fire && st_q[req_line] == LS_BUSY |=> rsp_valid && rsp_kind == RK_NACK);

   assert_inv_target_R4: assert property (@(posedge clk) disable iff (!rst_n)
      inv_valid |-> st_q[inv_line] == LS_BUSY && inv_node != own_q[inv_line]);

   assert_ack_pending_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ack_fire |-> st_q[ack_line] == LS_BUSY && cnt_q[ack_line] != '0
                   && ack_node != own_q[ack_line]);

   assert_stall_inputs_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && !rsp_ready |-> !req_ready && !ack_ready);
endmodule

// File: tb/dir_home_serializer_test.sv
module dir_home_serializer_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_valid = 1'b0, req_write = 1'b0;
   logic [1:0] req_node = '0;
   logic [2:0] req_line = '0;
   logic       ack_valid = 1'b0;
   logic [1:0] ack_node = '0;
   logic [2:0] ack_line = '0;
   logic       inv_ready = 1'b1, rsp_ready = 1'b1;
   logic       req_ready, ack_ready, inv_valid, rsp_valid;
   logic [1:0] inv_node, rsp_kind, rsp_node;
   logic [2:0] inv_line, rsp_line;

   int checks = 0, failures = 0;
   bit done = 1'b0;
   int    rsp_q[$];
   string rsp_tag[$];
   int    inv_q[$];

   always #2 clk = ~clk;  // 4 ns period

   dir_home_serializer #(.NODES(4), .LINES(8)) uut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
      .req_node(req_node), .req_line(req_line),
      .ack_valid(ack_valid), .ack_ready(ack_ready),
      .ack_node(ack_node), .ack_line(ack_line),
      .inv_valid(inv_valid), .inv_ready(inv_ready),
      .inv_node(inv_node), .inv_line(inv_line),
      .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
      .rsp_kind(rsp_kind), .rsp_node(rsp_node), .rsp_line(rsp_line)
   );

   task automatic chk(bit ok, string tag, int act, int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // reply code = kind*100 + node*10 + line; invalidation code = node*10 + line
   task automatic exp_rsp(int k, int n, int l, string tag);
      rsp_q.push_back(k*100 + n*10 + l);
      rsp_tag.push_back(tag);
   endtask

   task automatic exp_inv(int n, int l);
      inv_q.push_back(n*10 + l);
   endtask

   task automatic send_req(bit w, int n, int l);
      @(negedge clk);
      req_valid = 1'b1; req_write = w; req_node = 2'(n); req_line = 3'(l);
      #1;
      while (!req_ready) begin @(negedge clk); #1; end
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic send_ack(int n, int l);
      @(negedge clk);
      ack_valid = 1'b1; ack_node = 2'(n); ack_line = 3'(l);
      #1;
      while (!ack_ready) begin @(negedge clk); #1; end
      @(negedge clk);
      ack_valid = 1'b0;
   endtask

   task automatic wait_inv();
      while (inv_q.size() != 0) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   task automatic wait_idle();
      while (inv_q.size() != 0 || rsp_q.size() != 0) @(negedge clk);
      repeat (4) @(negedge clk);
   endtask

   // scoreboard monitor: one compare per transfer cycle
   always begin : monitor
      int a;
      string t;
      @(negedge clk); #1;
      if (rst_n && rsp_valid && rsp_ready) begin
         a = rsp_kind*100 + rsp_node*10 + rsp_line;
         if (rsp_q.size() == 0) chk(1'b0, "R5 reply with none due", a, -1);
         else begin
            t = rsp_tag.pop_front();
            chk(a == rsp_q[0], t, a, rsp_q[0]);
            void'(rsp_q.pop_front());
         end
      end
      if (rst_n && inv_valid && inv_ready) begin
         a = inv_node*10 + inv_line;
         if (inv_q.size() == 0) chk(1'b0, "R4 invalidation with none due", a, -1);
         else begin
            chk(a == inv_q[0], "R4 invalidation target/order", a, inv_q[0]);
            void'(inv_q.pop_front());
         end
      end
   end

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL R1 watchdog expired actual=0 expected=1");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin : main
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1; #1;
      // R1 reset state
      chk(rsp_valid == 1'b0, "R1 rsp_valid after reset", rsp_valid, 0);
      chk(inv_valid == 1'b0, "R1 inv_valid after reset", inv_valid, 0);
      chk(req_ready == 1'b1, "R1 req_ready after reset", req_ready, 1);
      exp_rsp(0, 1, 0, "R1 first read data"); send_req(0, 1, 0); wait_idle();

      // R2 more readers
      exp_rsp(0, 2, 0, "R2 read data"); send_req(0, 2, 0);
      exp_rsp(0, 3, 0, "R2 read data"); send_req(0, 3, 0); wait_idle();

      // R4 write with sharers n1,n2,n3 from n2
      exp_inv(1, 0); exp_inv(3, 0); send_req(1, 2, 0); wait_inv();
      // R6 busy refusals
      exp_rsp(2, 0, 0, "R6 read NACK"); send_req(0, 0, 0);
      exp_rsp(2, 1, 0, "R6 write NACK"); send_req(1, 1, 0); wait_idle();
      // R5 grant only after last ack; an early reply hits an empty queue
      send_ack(1, 0); repeat (4) @(negedge clk);
      exp_rsp(1, 2, 0, "R5 grant after last ack"); send_ack(3, 0); wait_idle();

      // R3 immediate grants
      exp_rsp(1, 2, 0, "R3 owner rewrite grant"); send_req(1, 2, 0);
      exp_rsp(1, 0, 1, "R3 uncached write grant"); send_req(1, 0, 1);
      exp_rsp(0, 3, 2, "R2 read data"); send_req(0, 3, 2);
      exp_rsp(1, 3, 2, "R3 sole sharer grant"); send_req(1, 3, 2); wait_idle();

      // R7 read of exclusive line
      exp_inv(2, 0); send_req(0, 1, 0); wait_inv();
      exp_rsp(0, 1, 0, "R7 data after owner ack"); send_ack(2, 0); wait_idle();
      exp_inv(1, 0); send_req(1, 3, 0); wait_inv();
      exp_rsp(1, 3, 0, "R7 reader sole sharer"); send_ack(1, 0); wait_idle();

      // R8 ack and request in the same cycle
      exp_inv(0, 1); send_req(1, 2, 1); wait_inv();
      exp_rsp(1, 2, 1, "R8 ack taken first");
      exp_rsp(0, 1, 3, "R8 request taken next");
      @(negedge clk);
      ack_valid = 1'b1; ack_node = 2'd0; ack_line = 3'd1;
      req_valid = 1'b1; req_write = 1'b0; req_node = 2'd1; req_line = 3'd3;
      #1;
      chk(req_ready == 1'b0, "R8 req_ready low with ack", req_ready, 0);
      chk(ack_ready == 1'b1, "R8 ack_ready", ack_ready, 1);
      @(negedge clk); ack_valid = 1'b0; #1;
      chk(req_ready == 1'b1, "R8 req_ready after ack", req_ready, 1);
      @(negedge clk); req_valid = 1'b0;
      wait_idle();

      // R9 reply backpressure
      rsp_ready = 1'b0;
      exp_rsp(0, 0, 4, "R9 held reply"); send_req(0, 0, 4);
      for (int i = 0; i < 3; i++) begin
         @(negedge clk); #1;
         chk(rsp_valid == 1'b1 && rsp_node == 2'd0 && rsp_line == 3'd4,
             "R9 reply held", rsp_node*10 + rsp_line, 4);
         chk(req_ready == 1'b0 && ack_ready == 1'b0, "R9 inputs stalled",
             req_ready, 0);
      end
      @(negedge clk); rsp_ready = 1'b1; wait_idle();

      // R10 invalidation backpressure
      exp_rsp(0, 0, 5, "R2 read data"); send_req(0, 0, 5);
      exp_rsp(0, 1, 5, "R2 read data"); send_req(0, 1, 5);
      exp_rsp(0, 2, 5, "R2 read data"); send_req(0, 2, 5); wait_idle();
      inv_ready = 1'b0;
      exp_inv(0, 5); exp_inv(1, 5); exp_inv(2, 5); send_req(1, 3, 5);
      for (int i = 0; i < 4; i++) begin
         @(negedge clk); #1;
         chk(inv_valid == 1'b1 && inv_node == 2'd0 && inv_line == 3'd5,
             "R10 invalidation held", inv_node*10 + inv_line, 5);
      end
      @(negedge clk); inv_ready = 1'b1; wait_inv();
      send_ack(0, 5); send_ack(1, 5);
      exp_rsp(1, 3, 5, "R5 grant after three acks"); send_ack(2, 5); wait_idle();

      chk(rsp_q.size() == 0, "R5 replies outstanding", rsp_q.size(), 0);
      chk(inv_q.size() == 0, "R4 invalidations outstanding", inv_q.size(), 0);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule